// File: doc/BRIEF.md
# Wiper Register Bank with Nonvolatile Store

This block holds the wiper positions of a multi-channel digital potentiometer and executes the commands that a serial front end has already decoded into a control code, a channel address and a data byte, presented with a one-cycle valid strobe. Each channel keeps three values. The working wiper register drives the wiper code output. A preload register holds a value for a later transfer into the wiper. A nonvolatile copy survives reset and is modelled here as a register array.

Writing the nonvolatile copy is slow. It takes a parameterized number of clock cycles, and during that time the block reports busy and discards every command it is given. After each reset the block spends one cycle reloading every wiper from its nonvolatile copy. This reset therefore stands in for a power cycle. Readback data comes back one cycle after the command together with a valid pulse.

Top module: `wiper_nv_bank`

## Requirements
- R1: After reset is released, the block spends one cycle with busy_o high and then loads every wiper from its nonvolatile copy. Before the first store, every nonvolatile copy holds midscale, 1 << (DATA_W-1), which is 0x80 for 8 bits. The nonvolatile copies are not cleared by reset, but the preload and control registers are cleared to zero.
- R2: Control code 1 writes the data byte into the wiper of the addressed channel, and the new code appears on wiper_o in the next cycle. Any number of writes is allowed.
- R3: Control code 2 writes the preload register of the addressed channel and leaves its wiper unchanged. Control code 8 copies that channel's preload register into its wiper.
- R4: Control code 3 reads a register of the addressed channel, selected by data bits [1:0]: 0 selects preload, 1 the nonvolatile copy, 2 the control register and 3 the wiper. rvalid_o pulses high for one cycle, with the value on rdata_o, in the cycle after the command.
- R5: Control code 9 captures the addressed channel's wiper and raises busy_o for exactly STORE_CYCLES cycles, starting the cycle after the command. The nonvolatile copy takes the captured value as busy_o falls, and the wiper does not change.
- R6: Control code 11 writes the data byte into the addressed channel's nonvolatile copy, with the same busy period as R5, and leaves the wiper unchanged.
- R7: While busy_o is high, every command is ignored. Wipers hold their values and rvalid_o stays low.
- R8: A channel address at or above NUM_CH is unassigned. A readback of it returns zero with rvalid_o high, and a write, transfer, store or nonvolatile write to it has no effect and raises no busy.
- R9: Control codes other than 1, 2, 3, 8, 9, 11 and 13 change no register, produce no readback and raise no busy.
- R10: With LSB_IGNORE set, bit 0 is forced to zero whenever a wiper or a nonvolatile copy is written or transferred.
- R11: Control code 13 writes the data byte into a single shared control register, which readback select 2 returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; also starts the restore cycle |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_ctrl_i | input | 4 | Control code |
| cmd_addr_i | input | ADDR_W | Channel address |
| cmd_data_i | input | DATA_W | Data byte or readback select |
| wiper_o | output | NUM_CH*DATA_W | Wiper codes, channel i at bits [i*DATA_W +: DATA_W] |
| rdata_o | output | DATA_W | Readback data |
| rvalid_o | output | 1 | Readback data valid, one cycle |
| busy_o | output | 1 | Restore or nonvolatile write in progress |

## Verification
The bench builds two copies of the block with four channels, 8-bit data and STORE_CYCLES set to 12. One copy has LSB_IGNORE cleared and the other has it set. The short store window puts the whole busy period, the commands that arrive during it and the commit at its end within a few dozen cycles. With the second copy the same stimulus also exercises the forced low bit. A second reset late in the run shows that the stored values survive into the next restore.

// File: rtl/wr_pkg.sv
package wr_pkg;

  typedef enum logic [3:0] {
    OP_WR_WIPER = 4'd1,
    OP_WR_INPUT = 4'd2,
    OP_READ     = 4'd3,
    OP_XFER     = 4'd8,
    OP_STORE    = 4'd9,
    OP_NV_WRITE = 4'd11,
    OP_WR_CTRL  = 4'd13
  } op_e;

  typedef enum logic [1:0] {
    SEL_INPUT = 2'd0,
    SEL_NV    = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_WIPER = 2'd3
  } rsel_e;

  typedef enum logic [1:0] {
    ST_RESTORE,
    ST_IDLE,
    ST_PROG
  } seq_e;

  typedef struct packed {
    logic wr_wiper;
    logic wr_input;
    logic xfer;
    logic read;
    logic store;
    logic nv_wr;
    logic wr_ctrl;
  } ops_t;

endpackage

// File: rtl/wr_cmd_decode.sv
module wr_cmd_decode
  import wr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic              valid_i,
  input  logic              idle_i,
  input  logic [3:0]        ctrl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output ops_t              ops_o,
  output logic              addr_ok_o,
  output logic [NUM_CH-1:0] chan_sel_o
);

  logic take;

  assign take      = valid_i & idle_i;
  assign addr_ok_o = int'(addr_i) < NUM_CH;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign chan_sel_o[i] = addr_ok_o && (int'(addr_i) == i);
  end

  // channel ops need a real channel; reads always answer
  always_comb begin
    ops_o = '0;
    if (take) begin
      case (ctrl_i)
        OP_WR_WIPER: ops_o.wr_wiper = addr_ok_o;
        OP_WR_INPUT: ops_o.wr_input = addr_ok_o;
        OP_XFER:     ops_o.xfer     = addr_ok_o;
        OP_READ:     ops_o.read     = 1'b1;
        OP_STORE:    ops_o.store    = addr_ok_o;
        OP_NV_WRITE: ops_o.nv_wr    = addr_ok_o;
        OP_WR_CTRL:  ops_o.wr_ctrl  = 1'b1;
        default:     ops_o          = '0;
      endcase
    end
  end

endmodule

// File: rtl/wr_prog_seq.sv
module wr_prog_seq
  import wr_pkg::*;
#(
  parameter int STORE_CYCLES = 1875000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic restore_o,
  output logic commit_o
);

  localparam int             CNT_W = $clog2(STORE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STORE_CYCLES - 1);

  seq_e             st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RESTORE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_RESTORE: st_q <= ST_IDLE;
        ST_IDLE: begin
          if (start_i) begin
            st_q  <= ST_PROG;
            cnt_q <= LOAD;
          end
        end
        ST_PROG: begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = st_q != ST_IDLE;
  assign restore_o = st_q == ST_RESTORE;
  assign commit_o  = (st_q == ST_PROG) && (cnt_q == '0);

endmodule

// File: rtl/wr_channel.sv
module wr_channel #(
  parameter int DATA_W     = 8,
  parameter bit LSB_IGNORE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restore_i,
  input  logic              wr_wiper_i,
  input  logic              wr_input_i,
  input  logic              xfer_i,
  input  logic              nv_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] nv_data_i,
  output logic [DATA_W-1:0] wiper_o,
  output logic [DATA_W-1:0] input_o,
  output logic [DATA_W-1:0] nv_o
);

  localparam logic [DATA_W-1:0] KEEP = LSB_IGNORE ? {{(DATA_W-1){1'b1}}, 1'b0}
                                                  : {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] MID  = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] wiper_q;
  logic [DATA_W-1:0] input_q;
  // nonvolatile copy: survives reset, only the initial content is fixed
  logic [DATA_W-1:0] nv_q = MID;

  always_ff @(posedge clk_i) begin
    if (nv_we_i) nv_q <= nv_data_i & KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper_q <= '0;
      input_q <= '0;
    end else begin
      if (restore_i)       wiper_q <= nv_q;
      else if (wr_wiper_i) wiper_q <= data_i & KEEP;
      else if (xfer_i)     wiper_q <= input_q & KEEP;
      if (wr_input_i)      input_q <= data_i;
    end
  end

  assign wiper_o = wiper_q;
  assign input_o = input_q;
  assign nv_o    = nv_q;

endmodule

// File: rtl/wiper_nv_bank.sv
module wiper_nv_bank
  import wr_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 4,
  parameter int STORE_CYCLES = 1875000,
  parameter bit LSB_IGNORE   = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_valid_i,
  input  logic [3:0]               cmd_ctrl_i,
  input  logic [ADDR_W-1:0]        cmd_addr_i,
  input  logic [DATA_W-1:0]        cmd_data_i,
  output logic [NUM_CH*DATA_W-1:0] wiper_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rvalid_o,
  output logic                     busy_o
);

  ops_t              ops;
  logic              addr_ok;
  logic [NUM_CH-1:0] chan_sel;
  logic              busy, restore, commit;

  logic [DATA_W-1:0] wiper_a [NUM_CH];
  logic [DATA_W-1:0] input_a [NUM_CH];
  logic [DATA_W-1:0] nv_a    [NUM_CH];

  logic [DATA_W-1:0] sel_wiper, sel_input, sel_nv, rdata_d;
  logic [DATA_W-1:0] pend_val_q, ctrl_q, rdata_q;
  logic [NUM_CH-1:0] pend_sel_q;
  logic              rvalid_q;

  wr_cmd_decode #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W)
  ) u_dec (
    .valid_i   (cmd_valid_i),
    .idle_i    (!busy),
    .ctrl_i    (cmd_ctrl_i),
    .addr_i    (cmd_addr_i),
    .ops_o     (ops),
    .addr_ok_o (addr_ok),
    .chan_sel_o(chan_sel)
  );

  wr_prog_seq #(
    .STORE_CYCLES(STORE_CYCLES)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (ops.store | ops.nv_wr),
    .busy_o   (busy),
    .restore_o(restore),
    .commit_o (commit)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    wr_channel #(
      .DATA_W    (DATA_W),
      .LSB_IGNORE(LSB_IGNORE)
    ) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restore_i (restore),
      .wr_wiper_i(ops.wr_wiper & chan_sel[i]),
      .wr_input_i(ops.wr_input & chan_sel[i]),
      .xfer_i    (ops.xfer & chan_sel[i]),
      .nv_we_i   (commit & pend_sel_q[i]),
      .data_i    (cmd_data_i),
      .nv_data_i (pend_val_q),
      .wiper_o   (wiper_a[i]),
      .input_o   (input_a[i]),
      .nv_o      (nv_a[i])
    );
    assign wiper_o[i*DATA_W +: DATA_W] = wiper_a[i];
  end

  // one-hot selected channel views
  always_comb begin
    sel_wiper = '0;
    sel_input = '0;
    sel_nv    = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      sel_wiper |= wiper_a[i] & {DATA_W{chan_sel[i]}};
      sel_input |= input_a[i] & {DATA_W{chan_sel[i]}};
      sel_nv    |= nv_a[i]    & {DATA_W{chan_sel[i]}};
    end
  end

  always_comb begin
    rdata_d = '0;
    if (addr_ok) begin
      case (rsel_e'(cmd_data_i[1:0]))
        SEL_INPUT: rdata_d = sel_input;
        SEL_NV:    rdata_d = sel_nv;
        SEL_CTRL:  rdata_d = ctrl_q;
        SEL_WIPER: rdata_d = sel_wiper;
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_val_q <= '0;
      pend_sel_q <= '0;
      ctrl_q     <= '0;
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
    end else begin
      if (ops.store | ops.nv_wr) begin
        pend_sel_q <= chan_sel;
        pend_val_q <= ops.store ? sel_wiper : cmd_data_i;
      end
      if (ops.wr_ctrl) ctrl_q <= cmd_data_i;
      rvalid_q <= ops.read;
      if (ops.read) rdata_q <= rdata_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign busy_o   = busy;

endmodule

// File: rtl/wiper_nv_bank_chk.sv
module wiper_nv_bank_chk #(
  parameter int NUM_CH       = 4,
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 4,
  parameter int STORE_CYCLES = 1875000,
  parameter bit LSB_IGNORE   = 1'b0
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cmd_valid_i,
  input logic [3:0]               cmd_ctrl_i,
  input logic [ADDR_W-1:0]        cmd_addr_i,
  input logic [NUM_CH*DATA_W-1:0] wiper_o,
  input logic [DATA_W-1:0]        rdata_o,
  input logic                     rvalid_o,
  input logic                     busy_o
);

  int run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  // R5
  store_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && (cmd_ctrl_i == 4'd9 || cmd_ctrl_i == 4'd11)
     && int'(cmd_addr_i) < NUM_CH) |=> busy_o);

  // R5 R1
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == STORE_CYCLES || run_q == 1));

  // R7
  lock_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && busy_o) |-> $stable(wiper_o));

  // R4
  rvalid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(cmd_valid_i && cmd_ctrl_i == 4'd3 && !busy_o));

  // R8
  bad_addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && int'($past(cmd_addr_i)) >= NUM_CH) |-> rdata_o == '0);

  if (LSB_IGNORE) begin : g_lsb
    for (genvar i = 0; i < NUM_CH; i++) begin : g_c
      // R10
      lsb_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wiper_o[i*DATA_W]);
    end
  end

endmodule

bind wiper_nv_bank wiper_nv_bank_chk #(
  .NUM_CH      (NUM_CH),
  .DATA_W      (DATA_W),
  .ADDR_W      (ADDR_W),
  .STORE_CYCLES(STORE_CYCLES),
  .LSB_IGNORE  (LSB_IGNORE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_ctrl_i (cmd_ctrl_i),
  .cmd_addr_i (cmd_addr_i),
  .wiper_o    (wiper_o),
  .rdata_o    (rdata_o),
  .rvalid_o   (rvalid_o),
  .busy_o     (busy_o)
);

// File: tb/wiper_nv_bank_test.sv
`timescale 1ns/1ps
module wiper_nv_bank_test;

  localparam int SC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cv = 1'b0;
  logic [3:0] cc = '0;
  logic [3:0] ca = '0;
  logic [7:0] cd = '0;

  logic [31:0] wip_w [2];
  logic [7:0]  rd_w  [2];
  logic        rv_w  [2];
  logic        bz_w  [2];

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string phase = "R1";

  always #4 clk = ~clk;

  wiper_nv_bank #(.NUM_CH(4), .DATA_W(8), .ADDR_W(4), .STORE_CYCLES(SC), .LSB_IGNORE(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cv), .cmd_ctrl_i(cc), .cmd_addr_i(ca),
    .cmd_data_i(cd), .wiper_o(wip_w[0]), .rdata_o(rd_w[0]), .rvalid_o(rv_w[0]), .busy_o(bz_w[0]));

  wiper_nv_bank #(.NUM_CH(4), .DATA_W(8), .ADDR_W(4), .STORE_CYCLES(SC), .LSB_IGNORE(1'b1)) uut_lo (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cv), .cmd_ctrl_i(cc), .cmd_addr_i(ca),
    .cmd_data_i(cd), .wiper_o(wip_w[1]), .rdata_o(rd_w[1]), .rvalid_o(rv_w[1]), .busy_o(bz_w[1]));

  // behavioural model, one per instance
  int m_wip [2][4];
  int m_inp [2][4];
  int m_nv  [2][4];
  int m_ctl [2];
  int m_cnt [2];
  int m_pch [2];
  int m_pval[2];
  int m_rd  [2];
  bit m_rv  [2];
  bit m_rest[2];

  initial begin
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 4; c++) m_nv[k][c] = 'h80;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < 2; k++) begin
      int mask;
      mask = (k == 0) ? 'hFF : 'hFE;
      if (!rst_n) begin
        for (int c = 0; c < 4; c++) begin
          m_wip[k][c] = 0;
          m_inp[k][c] = 0;
        end
        m_ctl[k] = 0; m_cnt[k] = 0; m_rv[k] = 0; m_rd[k] = 0; m_rest[k] = 1;
      end else begin
        m_rv[k] = 0;
        if (m_rest[k]) begin
          for (int c = 0; c < 4; c++) m_wip[k][c] = m_nv[k][c];
          m_rest[k] = 0;
        end else if (m_cnt[k] > 0) begin
          m_cnt[k]--;
          if (m_cnt[k] == 0) m_nv[k][m_pch[k]] = m_pval[k] & mask;
        end else if (cv) begin
          bit ok;
          int a;
          a  = int'(ca);
          ok = a < 4;
          case (int'(cc))
            1:  if (ok) m_wip[k][a] = int'(cd) & mask;
            2:  if (ok) m_inp[k][a] = int'(cd);
            8:  if (ok) m_wip[k][a] = m_inp[k][a] & mask;
            3: begin
              m_rv[k] = 1;
              if (!ok) m_rd[k] = 0;
              else case (int'(cd[1:0]))
                0: m_rd[k] = m_inp[k][a];
                1: m_rd[k] = m_nv[k][a];
                2: m_rd[k] = m_ctl[k];
                default: m_rd[k] = m_wip[k][a];
              endcase
            end
            9:  if (ok) begin m_pch[k] = a; m_pval[k] = m_wip[k][a]; m_cnt[k] = SC; end
            11: if (ok) begin m_pch[k] = a; m_pval[k] = int'(cd); m_cnt[k] = SC; end
            13: m_ctl[k] = int'(cd);
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < 2; k++) begin
        logic [31:0] ew;
        for (int c = 0; c < 4; c++) ew[c*8 +: 8] = m_wip[k][c][7:0];
        chk(phase, wip_w[k], ew);
        chk(phase, 32'(bz_w[k]), 32'(m_rest[k] || m_cnt[k] > 0));
        chk(phase, 32'(rv_w[k]), 32'(m_rv[k]));
        if (m_rv[k]) chk(phase, 32'(rd_w[k]), 32'(m_rd[k][7:0]));
      end
    end
  end

  task automatic cmd(int c, int a, int d);
    cv = 1'b1; cc = 4'(c); ca = 4'(a); cd = 8'(d);
    @(negedge clk);
    cv = 1'b0; cc = '0; ca = '0; cd = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 busy in restore", 32'(bz_w[0]), 32'd1);
    @(negedge clk);
    chk("R1 midscale", wip_w[0], 32'h80808080);
    chk("R1 busy cleared", 32'(bz_w[0]), 32'd0);

    phase = "R2";
    cmd(1, 0, 'h35);
    chk("R2", 32'(wip_w[0][7:0]), 32'h35);
    chk("R10", 32'(wip_w[1][7:0]), 32'h34);
    cmd(1, 3, 'hFF);
    cmd(1, 0, 'h36);
    chk("R2", wip_w[0], 32'hFF808036);
    chk("R10", wip_w[1], 32'hFE808036);

    phase = "R3";
    cmd(2, 1, 'h5B);
    chk("R3 preload only", 32'(wip_w[0][15:8]), 32'h80);
    cmd(8, 1, 0);
    chk("R3 transfer", 32'(wip_w[0][15:8]), 32'h5B);
    chk("R10 transfer", 32'(wip_w[1][15:8]), 32'h5A);

    phase = "R4";
    cmd(3, 1, 0);
    chk("R4 preload read", {rv_w[0], 23'd0, rd_w[0]}, 32'h8000005B);
    cmd(3, 3, 3);
    chk("R4 wiper read", 32'(rd_w[0]), 32'hFF);
    chk("R10 wiper read", 32'(rd_w[1]), 32'hFE);
    cmd(3, 0, 1);
    chk("R4 nv read", 32'(rd_w[0]), 32'h80);
    @(negedge clk);
    chk("R4 single pulse", 32'(rv_w[0]), 32'd0);

    phase = "R5";
    cmd(9, 0, 0);
    chk("R5 busy", 32'(bz_w[0]), 32'd1);
    phase = "R7";
    cmd(1, 0, 'h99);
    chk("R7 write ignored", 32'(wip_w[0][7:0]), 32'h36);
    cmd(3, 0, 3);
    chk("R7 read ignored", 32'(rv_w[0]), 32'd0);
    phase = "R5";
    begin
      int n;
      n = 0;
      while (bz_w[0]) begin n++; @(negedge clk); end
      chk("R5 busy length", 32'(n + 2), 32'(SC));
    end
    cmd(3, 0, 1);
    chk("R5 nv stored", 32'(rd_w[0]), 32'h36);
    chk("R5 wiper kept", 32'(wip_w[0][7:0]), 32'h36);

    phase = "R6";
    cmd(11, 2, 'h11);
    chk("R6 busy", 32'(bz_w[0]), 32'd1);
    while (bz_w[0]) @(negedge clk);
    chk("R6 wiper kept", 32'(wip_w[0][23:16]), 32'h80);
    cmd(3, 2, 1);
    chk("R6 nv", 32'(rd_w[0]), 32'h11);
    chk("R10 nv", 32'(rd_w[1]), 32'h10);

    phase = "R8";
    cmd(3, 7, 3);
    chk("R8 read zero", {rv_w[0], 23'd0, rd_w[0]}, 32'h80000000);
    cmd(1, 7, 'h44);
    cmd(9, 5, 0);
    chk("R8 no busy", 32'(bz_w[0]), 32'd0);
    chk("R8 wipers", wip_w[0], 32'hFF805B36);

    phase = "R9";
    cmd(5, 0, 'h12);
    cmd(15, 1, 'h13);
    cmd(0, 2, 'h14);
    chk("R9 no busy", 32'(bz_w[0]), 32'd0);
    chk("R9 no readback", 32'(rv_w[0]), 32'd0);
    chk("R9 wipers", wip_w[0], 32'hFF805B36);
    cmd(3, 0, 0);
    chk("R9 preload kept", 32'(rd_w[0]), 32'h00);

    phase = "R11";
    cmd(13, 0, 'hA7);
    cmd(3, 1, 2);
    chk("R11 ctrl read", 32'(rd_w[0]), 32'hA7);

    phase = "R1";
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 restore", wip_w[0], 32'h80118036);
    chk("R10 restore", wip_w[1], 32'h80108036);
    cmd(3, 1, 2);
    chk("R1 ctrl cleared", 32'(rd_w[0]), 32'h00);
    cmd(3, 1, 0);
    chk("R1 preload cleared", 32'(rd_w[0]), 32'h00);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule